// File: doc/BRIEF.md
# Two-Street Traffic Light Controller

This block sequences the lamps at a crossing of two streets, A and B. Each street has a green, a yellow and a red lamp, and the two streets take turns. A street shows green, then yellow, then red. An all-red clearance interval follows before the other street gets its green. The controller is a Moore machine: every lamp output is decoded from the present state alone.

Each street has a traffic sensor. While a street's sensor reports waiting traffic, that street's green is held past its minimum length, up to a hard cap. A pedestrian button, already synchronised to the clock, sets a request latch. A pending request is honoured after the next all-red clearance: both streets stay red for a walk interval with the walk lamp lit, and then the other street turns green. Every interval is measured by a single cycle counter that restarts on each state change. All lengths are parameters.

Top module: `trafficLightCtrl`

## Requirements
- R1: In every cycle each street lights exactly one of its three lamps, and the two streets are never green at the same time.
- R2: A synchronous active-high reset forces both streets red, turns the walk lamp off and drops any pending walk request. After release, all-red holds for R_LEN cycles and then street A turns green.
- R3: A green phase lasts at least G_MIN cycles. When the street's own sensor is low in the G_MIN-th green cycle or later, the next cycle shows yellow.
- R4: While a street's own sensor stays high, its green is extended, but never beyond G_MAX cycles in total. It then turns yellow even if the sensor is still high.
- R5: The sensor of the street that is red has no effect on the length of the other street's green.
- R6: Yellow lasts exactly Y_LEN cycles, followed by R_LEN cycles of all-red clearance. The green then passes to the other street, so A and B alternate.
- R7: A button press in any cycle is latched. After the next all-red clearance, a latched request adds W_LEN cycles in which both streets are red and the walk lamp is lit, before the other street turns green. Serving the request clears the latch, and no walk interval occurs without a request.
- R8: A press in the cycle whose clock edge starts a walk interval is not lost. It is served after the following clearance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| walkBtn | input | 1 | Synchronised pedestrian request |
| senseA | input | 1 | Traffic waiting on street A |
| senseB | input | 1 | Traffic waiting on street B |
| aGreen | output | 1 | Street A green lamp |
| aYellow | output | 1 | Street A yellow lamp |
| aRed | output | 1 | Street A red lamp |
| bGreen | output | 1 | Street B green lamp |
| bYellow | output | 1 | Street B yellow lamp |
| bRed | output | 1 | Street B red lamp |
| walkLamp | output | 1 | Pedestrian walk lamp |

## Verification
The bench builds the controller with G_MIN=3, G_MAX=6, Y_LEN=2, R_LEN=2 and W_LEN=3. With these values a full A-to-B-to-A rotation fits in a few dozen cycles. One cycle-exact script can therefore reach all of these cases:
- a green that ends at its minimum;
- a green that is extended and then ends when its sensor drops;
- a green that is cut off at the cap with its sensor still high;
- a served walk, and a walk re-armed by a press on its own start edge.

A short directed run then checks that a reset in mid-cycle drops a pending request.

// File: rtl/tlcPkg.sv
package tlcPkg;

  typedef enum logic [3:0] {
    ST_RST   = 4'd0,
    ST_AGRN  = 4'd1,
    ST_AYEL  = 4'd2,
    ST_ARED  = 4'd3,
    ST_AWALK = 4'd4,
    ST_BGRN  = 4'd5,
    ST_BYEL  = 4'd6,
    ST_BRED  = 4'd7,
    ST_BWALK = 4'd8
  } tlcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic walkClear;
  } tlcStrobe_t;

endpackage

// File: rtl/tlcDatapath.sv
module tlcDatapath
  import tlcPkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          walkBtn,
  input  tlcStrobe_t    strobe,
  output logic [CW-1:0] cnt,
  output logic          walkPending
);

  // cycles spent in the present state, restarted on every state change
  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  // request latch: a press in the serving cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      walkPending <= 1'b0;
    end else begin
      walkPending <= (walkPending & ~strobe.walkClear) | walkBtn;
    end
  end

  a_r7_press_latched: assert property (@(posedge clk) disable iff (rst)
    walkBtn |=> walkPending);

endmodule

// File: rtl/tlcFsm.sv
module tlcFsm
  import tlcPkg::*;
#(
  parameter int G_MIN = 3,
  parameter int G_MAX = 6,
  parameter int Y_LEN = 2,
  parameter int R_LEN = 2,
  parameter int W_LEN = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          senseA,
  input  logic          senseB,
  input  logic [CW-1:0] cnt,
  input  logic          walkPending,
  output tlcStrobe_t    strobe,
  output logic          aGreen,
  output logic          aYellow,
  output logic          aRed,
  output logic          bGreen,
  output logic          bYellow,
  output logic          bRed,
  output logic          walkLamp
);

  localparam logic [CW-1:0] GMIN_LAST = CW'(G_MIN - 1);
  localparam logic [CW-1:0] GMAX_LAST = CW'(G_MAX - 1);
  localparam logic [CW-1:0] Y_LAST    = CW'(Y_LEN - 1);
  localparam logic [CW-1:0] R_LAST    = CW'(R_LEN - 1);
  localparam logic [CW-1:0] W_LAST    = CW'(W_LEN - 1);

  tlcState_t state, nextState;
  logic      greenDoneA, greenDoneB;

  assign greenDoneA = ((cnt >= GMIN_LAST) && !senseA) || (cnt >= GMAX_LAST);
  assign greenDoneB = ((cnt >= GMIN_LAST) && !senseB) || (cnt >= GMAX_LAST);

  always_comb begin
    nextState = state;
    case (state)
      ST_RST:   if (cnt == R_LAST) nextState = ST_AGRN;
      ST_AGRN:  if (greenDoneA)    nextState = ST_AYEL;
      ST_AYEL:  if (cnt == Y_LAST) nextState = ST_ARED;
      ST_ARED:  if (cnt == R_LAST) nextState = walkPending ? ST_AWALK : ST_BGRN;
      ST_AWALK: if (cnt == W_LAST) nextState = ST_BGRN;
      ST_BGRN:  if (greenDoneB)    nextState = ST_BYEL;
      ST_BYEL:  if (cnt == Y_LAST) nextState = ST_BRED;
      ST_BRED:  if (cnt == R_LAST) nextState = walkPending ? ST_BWALK : ST_AGRN;
      ST_BWALK: if (cnt == W_LAST) nextState = ST_AGRN;
      default:                     nextState = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RST;
    else     state <= nextState;
  end

  assign strobe.cntClear  = (nextState != state);
  assign strobe.walkClear = (nextState != state) &&
                            ((nextState == ST_AWALK) || (nextState == ST_BWALK));

  // Moore decode
  assign aGreen   = (state == ST_AGRN);
  assign aYellow  = (state == ST_AYEL);
  assign aRed     = !(aGreen || aYellow);
  assign bGreen   = (state == ST_BGRN);
  assign bYellow  = (state == ST_BYEL);
  assign bRed     = !(bGreen || bYellow);
  assign walkLamp = (state == ST_AWALK) || (state == ST_BWALK);

  a_r2_starts_with_a: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RST) |=> (state == ST_RST || state == ST_AGRN));

  a_r3_green_min: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_AGRN || state == ST_BGRN) && cnt < GMIN_LAST) |=> $stable(state));

  a_r4_green_cap: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AGRN || state == ST_BGRN) |-> (cnt <= GMAX_LAST));

  a_r6_yellow_to_red: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AYEL) |=> (state == ST_AYEL || state == ST_ARED));

  a_r7_no_unrequested_walk: assert property (@(posedge clk) disable iff (rst)
    (!walkPending && (state == ST_ARED || state == ST_BRED)) |=> !walkLamp);

endmodule

// File: rtl/trafficLightCtrl.sv
module trafficLightCtrl
  import tlcPkg::*;
#(
  parameter int G_MIN = 8,
  parameter int G_MAX = 24,
  parameter int Y_LEN = 4,
  parameter int R_LEN = 2,
  parameter int W_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic walkBtn,
  input  logic senseA,
  input  logic senseB,
  output logic aGreen,
  output logic aYellow,
  output logic aRed,
  output logic bGreen,
  output logic bYellow,
  output logic bRed,
  output logic walkLamp
);

  localparam int LONG1   = (G_MAX > Y_LEN) ? G_MAX : Y_LEN;
  localparam int LONG2   = (R_LEN > W_LEN) ? R_LEN : W_LEN;
  localparam int LONGEST = (LONG1 > LONG2) ? LONG1 : LONG2;
  localparam int CW      = $clog2(LONGEST) + 1;

  tlcStrobe_t    strobe;
  logic [CW-1:0] cnt;
  logic          walkPending;

  tlcDatapath #(.CW(CW)) uDatapath (
    .clk        (clk),
    .rst        (rst),
    .walkBtn    (walkBtn),
    .strobe     (strobe),
    .cnt        (cnt),
    .walkPending(walkPending)
  );

  tlcFsm #(
    .G_MIN(G_MIN), .G_MAX(G_MAX), .Y_LEN(Y_LEN),
    .R_LEN(R_LEN), .W_LEN(W_LEN), .CW(CW)
  ) uFsm (
    .clk        (clk),
    .rst        (rst),
    .senseA     (senseA),
    .senseB     (senseB),
    .cnt        (cnt),
    .walkPending(walkPending),
    .strobe     (strobe),
    .aGreen     (aGreen),
    .aYellow    (aYellow),
    .aRed       (aRed),
    .bGreen     (bGreen),
    .bYellow    (bYellow),
    .bRed       (bRed),
    .walkLamp   (walkLamp)
  );

  a_r1_no_dual_green: assert property (@(posedge clk) disable iff (rst)
    !(aGreen && bGreen));

endmodule

// File: tb/tb_trafficLightCtrl.sv
module tb_trafficLightCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 37;

  // {walkBtn,senseA,senseB, walkLamp,aRed,aYellow,aGreen,bRed,bYellow,bGreen}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b000_0100100, 10'b000_0100100, 10'b000_0001100, 10'b000_0001100,
    10'b000_0001100, 10'b000_0010100, 10'b000_0010100, 10'b000_0100100,
    10'b000_0100100, 10'b001_0100001, 10'b101_0100001, 10'b001_0100001,
    10'b001_0100001, 10'b001_0100001, 10'b001_0100001, 10'b000_0100010,
    10'b000_0100010, 10'b000_0100100, 10'b100_0100100, 10'b000_1100100,
    10'b000_1100100, 10'b000_1100100, 10'b010_0001100, 10'b010_0001100,
    10'b010_0001100, 10'b000_0001100, 10'b000_0010100, 10'b000_0010100,
    10'b000_0100100, 10'b000_0100100, 10'b000_1100100, 10'b000_1100100,
    10'b000_1100100, 10'b010_0100001, 10'b010_0100001, 10'b010_0100001,
    10'b000_0100010
  };

  logic clk = 1'b0;
  logic rst, walkBtn, senseA, senseB;
  logic aGreen, aYellow, aRed, bGreen, bYellow, bRed, walkLamp;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trafficLightCtrl #(
    .G_MIN(3), .G_MAX(6), .Y_LEN(2), .R_LEN(2), .W_LEN(3)
  ) dut (
    .clk(clk), .rst(rst), .walkBtn(walkBtn), .senseA(senseA), .senseB(senseB),
    .aGreen(aGreen), .aYellow(aYellow), .aRed(aRed),
    .bGreen(bGreen), .bYellow(bYellow), .bRed(bRed), .walkLamp(walkLamp)
  );

  function automatic logic [6:0] lamps();
    return {walkLamp, aRed, aYellow, aGreen, bRed, bYellow, bGreen};
  endfunction

  function automatic string reqOf(int i);
    if (i < 3)  return "R2";
    if (i < 6)  return "R3";
    if (i < 10) return "R6";
    if (i < 16) return "R4";
    if (i < 19) return "R6";
    if (i < 22) return "R7";
    if (i < 27) return "R4";
    if (i < 30) return "R6";
    if (i < 33) return "R8";
    return "R5";
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: lamps actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // R1: one lamp per street, never both green
  task automatic checkSane();
    nChecks++;
    if (($countones({aRed, aYellow, aGreen}) != 1) ||
        ($countones({bRed, bYellow, bGreen}) != 1) || (aGreen && bGreen)) begin
      nFails++;
      $display("FAIL R1 at %0t: lamps actual %b expected one per street, no dual green",
               $time, lamps());
    end
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish();
    end
  end

  initial begin
    rst = 1'b1; walkBtn = 1'b0; senseA = 1'b0; senseB = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // vector walk: check the present state, then drive inputs for this cycle
    for (int i = 0; i < NVEC; i++) begin
      check(reqOf(i), lamps(), VEC[i][6:0]);
      checkSane();
      {walkBtn, senseA, senseB} = VEC[i][9:7];
      @(negedge clk);
    end

    // R2: reset mid-run with a press in the same cycle
    walkBtn = 1'b1; rst = 1'b1; senseA = 1'b0; senseB = 1'b0;
    @(negedge clk);
    check("R2", lamps(), 7'b0100100);
    walkBtn = 1'b0; rst = 1'b0;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      if (c == 1) check("R2", lamps(), 7'b0100100);
      if (c == 2) check("R2", lamps(), 7'b0001100);
      if (c == 9) check("R2", lamps(), 7'b0100001); // dropped request: no walk
    end
    checkSane();
    finish();
  end

endmodule